// File: doc/BRIEF.md
# Generation-Tagged Fast-Clear RAM

A single-port synchronous RAM that software and datapath logic see as erased to zero in a single cycle. No storage cell is reset by a clear. Each word carries a small generation tag, and one global key register stands for the "current" generation. A clear only steps that key by one. Any word whose tag is not the current key reads as zero. A foreground read that finds such a stale word also writes zero into it and retags it.

Idle cycles drive a scrub pointer round the array. It zeroes and retags every word whose tag is behind the current key. The block records the key that was current when the last complete sweep began. That value is the oldest generation that can still sit in the tag store. A clear that would step the key onto that generation is held back until the scrubber has made it safe, and `clear_ready_o` is low while it waits.

After reset the block spends one sweep of the whole array setting every tag and word to zero. Foreground access has priority over the scrubber. Read data appears one cycle after the read.

Top module: `fast_clear_ram`

## Requirements
- R1: After reset is released, `clear_ready_o` stays low for exactly DEPTH rising edges (the initialisation sweep) and then goes high. `rdata_o` is zero after reset. Every address then reads zero.
- R2: A read (access valid, write enable low) presents the stored word on `rdata_o` after the next rising edge. A write followed by a read of the same address returns the written word, with accesses back to back.
- R3: After an accepted clear, every address reads zero until it is written again. A word written after the clear reads back normally.
- R4: A read issued in the same cycle as a clear still returns the data from before the clear. A read of that address in a later cycle returns zero.
- R5: A write issued in the same cycle as a clear belongs to the old generation, so a later read of that address returns zero.
- R6: `rdata_o` holds its value in every cycle without a foreground read.
- R7: Each accepted clear advances the key by exactly one. After 2^KEY_W−1 clears with no idle cycle in between (following a completed sweep), `clear_ready_o` is low and a further clear is held. While held, it has no effect on reads. It takes effect once idle cycles complete a sweep, and `clear_ready_o` then returns high.
- R8: The scrubber never disturbs a word written in the current generation, even over many idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | One-cycle clear strobe |
| acc_valid_i | input | 1 | Foreground access this cycle |
| wr_en_i | input | 1 | 1 = write, 0 = read (with acc_valid_i) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| clear_ready_o | output | 1 | High when a clear would be accepted at once |

## Verification
The assertions assume that the control inputs are never unknown after reset. They also assume that a caller does not count on foreground accesses during the initialisation sweep, because the block ignores those accesses. The bench waits for `clear_ready_o` after reset before it issues any access. It holds a clear back only by keeping the access strobe high in every cycle, which starves the scrubber in a known way. It always leaves enough idle cycles for the pending clear to be released.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  typedef enum logic [1:0] {
    WR_NONE,
    WR_FG,
    WR_ZERO_FG,
    WR_ZERO_PTR
  } wr_src_e;
endpackage

// File: rtl/fcr_data_ram.sv
module fcr_data_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fcr_tag_store.sv
module fcr_tag_store #(
  parameter int KEY_W  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [KEY_W-1:0]  wtag_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [KEY_W-1:0]  rtag_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [KEY_W-1:0]  rtag_b_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [KEY_W-1:0] tag_q [DEPTH];

  // no reset: the init sweep writes every entry
  always_ff @(posedge clk_i) begin
    if (we_i) tag_q[waddr_i] <= wtag_i;
  end

  assign rtag_a_o = tag_q[raddr_a_i];
  assign rtag_b_o = tag_q[raddr_b_i];
endmodule

// File: rtl/fcr_key_ctrl.sv
module fcr_key_ctrl #(
  parameter int KEY_W  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              idle_i,
  output logic [KEY_W-1:0]  key_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              init_o,
  output logic              ready_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [KEY_W-1:0]  key_q, floor_q, start_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              init_q, pend_q;
  logic              safe, clr_req;

  // oldest generation possibly present must not be reached
  assign safe    = (key_q + KEY_W'(1)) != floor_q;
  assign clr_req = clear_i | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q   <= '0;
      floor_q <= '0;
      start_q <= '0;
      ptr_q   <= '0;
      init_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (init_q) begin
        ptr_q <= ptr_q + ADDR_W'(1);
        if (ptr_q == LAST) init_q <= 1'b0;
      end else if (idle_i) begin
        ptr_q <= ptr_q + ADDR_W'(1);
        if (ptr_q == '0)  start_q <= key_q;
        if (ptr_q == LAST) floor_q <= start_q;
      end
      if (clr_req) begin
        if (!init_q && safe) begin
          key_q  <= key_q + KEY_W'(1);
          pend_q <= 1'b0;
        end else begin
          pend_q <= 1'b1;
        end
      end
    end
  end

  assign key_o   = key_q;
  assign ptr_o   = ptr_q;
  assign init_o  = init_q;
  assign ready_o = !init_q && safe && !pend_q;

  // R7
  key_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_q != $past(key_q)) |-> (key_q == $past(key_q) + KEY_W'(1)));
  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_q != $past(key_q)) |-> (key_q != $past(floor_q)));
  // R1
  init_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |-> !ready_o);
endmodule

// File: rtl/fast_clear_ram.sv
module fast_clear_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int KEY_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              acc_valid_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clear_ready_o
);
  import fcr_pkg::*;

  logic [KEY_W-1:0]  key, tag_a, tag_b;
  logic [ADDR_W-1:0] ptr, waddr;
  logic [DATA_W-1:0] mem_rd, mem_wd, rdata_q;
  logic              init_busy, fg, rd_fire, hit, we;
  wr_src_e           wr_src;

  assign fg      = acc_valid_i && !init_busy;
  assign rd_fire = fg && !wr_en_i;
  assign hit     = tag_a == key;

  fcr_key_ctrl #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .idle_i  (!acc_valid_i),
    .key_o   (key),
    .ptr_o   (ptr),
    .init_o  (init_busy),
    .ready_o (clear_ready_o)
  );

  always_comb begin
    if (init_busy)                           wr_src = WR_ZERO_PTR;
    else if (fg && wr_en_i)                  wr_src = WR_FG;
    else if (rd_fire && !hit)                wr_src = WR_ZERO_FG;
    else if (!acc_valid_i && (tag_b != key)) wr_src = WR_ZERO_PTR;
    else                                     wr_src = WR_NONE;
  end

  always_comb begin
    we     = wr_src != WR_NONE;
    waddr  = (wr_src == WR_ZERO_PTR) ? ptr : addr_i;
    mem_wd = (wr_src == WR_FG) ? wdata_i : '0;
  end

  fcr_tag_store #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_tags (
    .clk_i     (clk_i),
    .we_i      (we),
    .waddr_i   (waddr),
    .wtag_i    (key),
    .raddr_a_i (addr_i),
    .rtag_a_o  (tag_a),
    .raddr_b_i (ptr),
    .rtag_b_o  (tag_b)
  );

  fcr_data_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (mem_wd),
    .raddr_i (addr_i),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_fire) rdata_q <= hit ? mem_rd : '0;
  end

  assign rdata_o = rdata_q;

  // R3
  stale_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && !hit) |=> (rdata_o == '0));
  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_fire |=> $stable(rdata_o));
  // R8
  scrub_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fg && wr_en_i) |-> (waddr == addr_i && mem_wd == wdata_i));
endmodule

// File: tb/fast_clear_ram_tb.sv
`timescale 1ns/1ps
module fast_clear_ram_tb;
  localparam int DW = 16, AW = 4, KW = 2, DEPTH = 1 << AW;

  logic clk = 0, rst_ni = 0, clear_i = 0, acc_valid_i = 0, wr_en_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0, rdata_o;
  logic clear_ready_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fast_clear_ram #(.DATA_W(DW), .ADDR_W(AW), .KEY_W(KW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .acc_valid_i(acc_valid_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .clear_ready_o(clear_ready_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic c, logic v, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    clear_i = c; acc_valid_i = v; wr_en_i = w; addr_i = a; wdata_i = d;
    @(posedge clk); #1;
    clear_i = 0; acc_valid_i = 0; wr_en_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    cyc(0, 1, 1, a, d);
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    cyc(0, 1, 0, a, '0);
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_ni = 1;
    chk("R1 ready low after reset", clear_ready_o, 0);
    chk("R1 rdata zero after reset", rdata_o, 0);
    idle(DEPTH - 1);
    chk("R1 ready low before sweep end", clear_ready_o, 0);
    idle(1);
    chk("R1 ready high after sweep", clear_ready_o, 1);
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), '0, "R1 initial contents zero");
  endtask

  task automatic t_wr_rd();
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), DW'(16'h1000 + a * 16'h0111));
    for (int a = DEPTH - 1; a >= 0; a--) rd(AW'(a), DW'(16'h1000 + a * 16'h0111), "R2 readback");
    wr(4'd2, 16'hBEEF);
    rd(4'd2, 16'hBEEF, "R2 write then read back to back");
  endtask

  task automatic t_rd_hold();
    rd(4'd2, 16'hBEEF, "R6 setup read");
    idle(3);
    chk("R6 hold over idle", rdata_o, 16'hBEEF);
    wr(4'd4, 16'h1234);
    chk("R6 hold over write", rdata_o, 16'hBEEF);
  endtask

  task automatic t_clear();
    idle(40);
    cyc(1, 0, 0, '0, '0);
    rd(4'd2, '0, "R3 zero after clear");
    rd(4'd7, '0, "R3 other address zero after clear");
    wr(4'd2, 16'hCAFE);
    rd(4'd2, 16'hCAFE, "R3 write after clear");
  endtask

  task automatic t_clear_read();
    idle(40);
    wr(4'd5, 16'hA5A5);
    cyc(1, 1, 0, 4'd5, '0);
    chk("R4 read in clear cycle sees old data", rdata_o, 16'hA5A5);
    rd(4'd5, '0, "R4 later read zero");
  endtask

  task automatic t_clear_write();
    idle(40);
    cyc(1, 1, 1, 4'd6, 16'h6666);
    rd(4'd6, '0, "R5 write in clear cycle wiped");
  endtask

  task automatic t_hold_off();
    idle(40);
    wr(4'd9, 16'h9999);
    idle(40);
    rd(4'd9, 16'h9999, "R8 scrub keeps current data");
    chk("R7 ready before burst", clear_ready_o, 1);
    wr(4'd7, 16'h7777);
    cyc(1, 1, 0, 4'd7, '0);
    chk("R7 read in first clear", rdata_o, 16'h7777);
    cyc(1, 1, 0, 4'd7, '0);
    chk("R7 zero after first clear", rdata_o, 0);
    cyc(1, 1, 0, 4'd7, '0);
    chk("R7 ready low after 3 clears", clear_ready_o, 0);
    cyc(1, 1, 1, 4'd8, 16'h8888);
    chk("R7 ready low while held", clear_ready_o, 0);
    rd(4'd8, 16'h8888, "R7 held clear not applied");
    begin
      int n = 0;
      while (!clear_ready_o && n < 100) begin idle(1); n++; end
      chk("R7 ready returns", clear_ready_o, 1);
    end
    rd(4'd8, '0, "R7 held clear applied");
  endtask

  initial begin
    fork
      begin
        t_reset(); t_wr_rd(); t_rd_hold(); t_clear();
        t_clear_read(); t_clear_write(); t_hold_off();
        done = 1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule